// File: doc/BRIEF.md
# Dual-Clock 16-to-32 Packing Stream FIFO

This block carries a stream of 16-bit samples from a source clock domain, typically recovered from a serial link, into an independent system clock domain. On the way it packs each pair of samples into one 32-bit word. The read side is a ready/valid stream that can drive a memory write engine directly. The head word is always present on the output, and the consumer's ready acts as the read request. No second buffering stage or glue logic is needed between the FIFO and the consumer.

Storage is a dual-clock memory of `DEPTH` 32-bit words. The depth is a power of two and at least 16. Write and read pointers cross between the domains as Gray code through two-flop synchronisers. The full flag is computed on the write side and the empty flag on the read side. The write side has no backpressure. If a sample pair completes while the storage is full, the word is thrown away and a sticky overflow flag is raised. Nothing is recovered. Each domain has its own asynchronous reset, and the block releases that reset synchronously to the local clock.

Top module: `cdc_pack_fifo`

## Requirements
- R1: After either reset, `rd_valid` is low and `ovf_flag` is low.
- R2: Two consecutive accepted samples form one word. The earlier sample goes to bits [15:0] and the later sample to bits [31:16].
- R3: Words leave the read port in the order in which they were completed on the write side.
- R4: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` holds the same head word.
- R5: A word is removed only on a `rd_clk` edge where `rd_valid` and `rd_ready` are both high. Once the last word is removed, `rd_valid` goes low.
- R6: The FIFO holds exactly `DEPTH` words. A pair that completes while the FIFO is full is discarded as a whole, and `ovf_flag` is set and stays set.
- R7: `ovf_clr` high on a `wr_clk` edge clears `ovf_flag`. If an overflow happens on the same edge, the flag stays set.
- R8: A single unpaired sample produces no output word. It is held until its partner arrives.
- R9: A completed word appears as `rd_valid` high within 6 `rd_clk` cycles of the write edge that completed it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Source-side clock |
| wr_rst_n | input | 1 | Source-side asynchronous reset, active low |
| wr_en | input | 1 | Sample strobe, one sample per high cycle |
| wr_data | input | 16 | Incoming sample |
| ovf_clr | input | 1 | Clears the overflow flag, active high |
| ovf_flag | output | 1 | Sticky overflow indication (write domain) |
| rd_clk | input | 1 | System-side clock |
| rd_rst_n | input | 1 | System-side asynchronous reset, active low |
| rd_valid | output | 1 | Head word present |
| rd_ready | input | 1 | Consumer accepts the head word |
| rd_data | output | 32 | Head word (show-ahead) |

## Verification
A stuck or misaligned pairing register shows up at the very first output word as swapped or duplicated halves. A pointer or Gray-sync fault shows up as repeated, skipped or reordered words, or as `rd_valid` that never rises or never falls, within a few read cycles of the affected write. A wrong full comparison shows up only at the capacity boundary. There it appears as a missing or false `ovf_flag`, or as an extra word read back after the FIFO has been filled, so the bench deliberately drives the FIFO to exactly `DEPTH` words and one beyond.

// File: rtl/cdc_pack_fifo.sv
module cdc_pack_fifo #(
  parameter int IN_W  = 16,
  parameter int DEPTH = 16
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [IN_W-1:0]   wr_data,
  input  logic              ovf_clr,
  output logic              ovf_flag,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [2*IN_W-1:0] rd_data
);
  localparam int OUT_W = 2 * IN_W;
  localparam int AW    = $clog2(DEPTH);

  generate
    if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 16");
    end
  endgenerate

  logic [OUT_W-1:0] mem [DEPTH];

  // write domain
  logic [1:0]      wsync;
  logic            wrst_n;
  logic [IN_W-1:0] lo_q;
  logic            lo_v;
  logic [AW:0]     wbin, wgray, rg_s1, rg_s2;
  logic [AW:0]     rgray;

  assign wrst_n = wsync[1];

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) wsync <= '0;
    else           wsync <= {wsync[0], 1'b1};

  wire [AW:0] wbin_nx   = wbin + 1'b1;
  wire        pair_done = wr_en && lo_v;
  wire        full      = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  wire        do_wr     = pair_done && !full;

  always_ff @(posedge wr_clk or negedge wrst_n)
    if (!wrst_n) begin
      lo_q     <= '0;
      lo_v     <= 1'b0;
      wbin     <= '0;
      wgray    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        lo_v <= !lo_v;
        if (!lo_v) lo_q <= wr_data;
      end
      if (do_wr) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (pair_done && full) ovf_flag <= 1'b1;
      else if (ovf_clr)      ovf_flag <= 1'b0;
    end

  always_ff @(posedge wr_clk or negedge wrst_n)
    if (!wrst_n) {rg_s2, rg_s1} <= '0;
    else         {rg_s2, rg_s1} <= {rg_s1, rgray};

  always_ff @(posedge wr_clk)
    if (do_wr) mem[wbin[AW-1:0]] <= {wr_data, lo_q};

  // read domain
  logic [1:0]  rsync;
  logic        rrst_n;
  logic [AW:0] rbin, wg_s1, wg_s2;

  assign rrst_n = rsync[1];

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) rsync <= '0;
    else           rsync <= {rsync[0], 1'b1};

  wire [AW:0] rbin_nx = rbin + 1'b1;
  wire        pop     = rd_valid && rd_ready;

  assign rd_valid = (rgray != wg_s2);
  assign rd_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rrst_n)
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end

  always_ff @(posedge rd_clk or negedge rrst_n)
    if (!rrst_n) {wg_s2, wg_s1} <= '0;
    else         {wg_s2, wg_s1} <= {wg_s1, wgray};
endmodule

module cdc_pack_fifo_chk #(
  parameter int OUT_W = 32,
  parameter int AW    = 4
) (
  input logic             wr_clk,
  input logic             wr_rst_n,
  input logic             wr_en,
  input logic             ovf_clr,
  input logic             ovf_flag,
  input logic             lo_v,
  input logic             full,
  input logic [AW:0]      wbin,
  input logic             rd_clk,
  input logic             rd_rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [OUT_W-1:0] rd_data,
  input logic [AW:0]      rbin
);
  a_r4_head_held: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r5_read_only_on_handshake: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_valid && rd_ready) |=> $stable(rbin));

  a_r6_full_discards: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    full && lo_v && wr_en |=> $stable(wbin) && ovf_flag);

  a_r6_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  a_r7_clear: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ovf_clr && !wr_en |=> !ovf_flag);

  a_r8_lone_half_no_write: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en && !lo_v |=> $stable(wbin));
endmodule

bind cdc_pack_fifo cdc_pack_fifo_chk #(.OUT_W(OUT_W), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .ovf_clr(ovf_clr),
  .ovf_flag(ovf_flag), .lo_v(lo_v), .full(full), .wbin(wbin),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rbin(rbin)
);

// File: tb/tb_cdc_pack_fifo.sv
`timescale 1ns/1ps
module tb_cdc_pack_fifo;
  localparam int DEPTH = 16;

  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        wr_en = 0, ovf_clr = 0, rd_ready = 0;
  logic [15:0] wr_data = '0;
  logic        ovf_flag, rd_valid;
  logic [31:0] rd_data;

  int errors = 0, checks = 0;

  always #2.5 rd_clk = ~rd_clk;
  always #3   wr_clk = ~wr_clk;

  cdc_pack_fifo #(.IN_W(16), .DEPTH(DEPTH)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data));

  localparam logic [15:0] VEC [8] = '{16'h1111, 16'h2222, 16'hA5A5, 16'h5A5A,
                                      16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic push(input logic [15:0] s);
    @(negedge wr_clk);
    wr_en = 1; wr_data = s;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    @(negedge rd_clk);
    while (!rd_valid && n < 50) begin
      @(negedge rd_clk);
      n++;
    end
  endtask

  task automatic pop_expect(input string req, input logic [31:0] exp);
    int n;
    wait_valid(n);
    check(req, {31'b0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
    rd_ready = 1;
    @(negedge rd_clk);
    rd_ready = 0;
  endtask

  task automatic idle_rd(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int n;
    logic [31:0] held;
    #1;
    check("R1 valid", {31'b0, rd_valid}, 0);
    check("R1 ovf", {31'b0, ovf_flag}, 0);
    #40;
    wr_rst_n = 1; rd_rst_n = 1;
    idle_rd(10);
    check("R1 valid after release", {31'b0, rd_valid}, 0);
    check("R1 ovf after release", {31'b0, ovf_flag}, 0);

    // table walk: R2 packing, R3 order
    for (int i = 0; i < 8; i++) push(VEC[i]);
    for (int i = 0; i < 4; i++) pop_expect("R2/R3 table", {VEC[2*i+1], VEC[2*i]});
    idle_rd(6);
    check("R5 empty after drain", {31'b0, rd_valid}, 0);

    // R8 lone half held, R9 latency
    push(16'hBEEF);
    idle_rd(12);
    check("R8 lone half not visible", {31'b0, rd_valid}, 0);
    @(negedge wr_clk);
    wr_en = 1; wr_data = 16'hCAFE;
    @(negedge wr_clk);
    wr_en = 0;
    wait_valid(n);
    check("R9 latency", {31'b0, (n <= 6)}, 1);
    check("R8 paired word", rd_data, 32'hCAFEBEEF);

    // R4 head held while not ready
    held = rd_data;
    idle_rd(5);
    check("R4 valid held", {31'b0, rd_valid}, 1);
    check("R4 data held", rd_data, held);
    pop_expect("R5 pop", 32'hCAFEBEEF);
    idle_rd(2);
    check("R5 valid falls", {31'b0, rd_valid}, 0);

    // R6 fill to capacity, then one more pair
    idle_rd(10);
    for (int i = 0; i < DEPTH; i++) begin
      push(16'(2*i)); push(16'(2*i+1) | 16'h4000);
    end
    @(negedge wr_clk);
    check("R6 no ovf at capacity", {31'b0, ovf_flag}, 0);
    push(16'hDEAD); push(16'hF00D);
    @(negedge wr_clk);
    check("R6 ovf set", {31'b0, ovf_flag}, 1);
    repeat (4) @(negedge wr_clk);
    check("R6 ovf sticky", {31'b0, ovf_flag}, 1);
    for (int i = 0; i < DEPTH; i++)
      pop_expect("R6 drain", {16'(2*i+1) | 16'h4000, 16'(2*i)});
    idle_rd(6);
    check("R6 extra word discarded", {31'b0, rd_valid}, 0);

    // R7 clear
    @(negedge wr_clk);
    ovf_clr = 1;
    @(negedge wr_clk);
    ovf_clr = 0;
    check("R7 cleared", {31'b0, ovf_flag}, 0);

    // R7 overflow wins over clear on the same edge
    repeat (6) @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      push(16'(i)); push(16'(i + 100));
    end
    push(16'h1234);
    @(negedge wr_clk);
    wr_en = 1; wr_data = 16'h5678; ovf_clr = 1;
    @(negedge wr_clk);
    wr_en = 0; ovf_clr = 0;
    check("R7 set wins over clear", {31'b0, ovf_flag}, 1);
    for (int i = 0; i < DEPTH; i++)
      pop_expect("R3 order after refill", {16'(i + 100), 16'(i)});
    idle_rd(6);
    check("R5 empty at end", {31'b0, rd_valid}, 0);

    summary();
  end
endmodule